// File: doc/BRIEF.md
# Self-Gated Shift Register Bank with Warm-Up Feedback

The block holds a bank of equal-width shift registers that share one clock, one enable and one serial input. On every enabled clock each register looks at one of its own bits, its move flag. It advances by one place only when that flag is 1. The registers therefore stall and advance independently of each other in the same cycle.

The last register in the bank is a feedback shift register with XOR taps. After a load, its top bits hold values that cannot yet be used. For its first moves it shifts in the serial input, and it inserts feedback only after it has filled those bits. A ready flag reports when feedback insertion has begun. All registers can be loaded in parallel. Each register's top bit is brought out as a serial output.

Top module: `shreg_bank`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, every register reads zero and ready_o is 0.
- R2: When load_i is 1 at a clock edge, every register takes its slice of ld_val_i (lane k from bits [k*11+10:k*11]) and the warm-up count is cleared, so ready_o is 0 afterwards. Load overrides en_i and all shifting.
- R3: When load_i is 0 and en_i is 0, no register changes and ready_o keeps its value.
- R4: When en_i is 1, a register whose bit 5 is 0 keeps its value. If that register is the feedback register, its hold does not advance the warm-up.
- R5: When en_i is 1, a register whose bit 5 is 1 moves bit i to bit i+1 and drops bit 10.
- R6: On a move, lanes 0 and 1 take ser_i into bit 0.
- R7: After a load or reset, the first two moves of lane 2 take ser_i into bit 0, and ready_o stays 0 until both have happened.
- R8: ready_o goes to 1 on the clock of the second lane-2 move and stays 1 until the next load or reset. Each later lane-2 move puts into bit 0 the XOR of bits 10, 9, 8 and 4 of that register as they were before the move.
- R9: ser_o[k] always equals bit 10 of lane k.
- R10: The three move flags are evaluated in the same cycle and each acts on its own register only, so some lanes can stall while others shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Synchronous parallel load of all lanes |
| en_i | input | 1 | Global shift enable |
| ser_i | input | 1 | Serial data input |
| ld_val_i | input | 33 | Load values, lane k at bits [k*11+10:k*11] |
| q_o | output | 33 | Parallel contents, lane k at bits [k*11+10:k*11] |
| ser_o | output | 3 | Bit 10 of each lane |
| ready_o | output | 1 | Warm-up complete, feedback active on lane 2 |

## Verification
The bench builds the block with its default parameters: three 11-bit lanes, move flag at bit 5, taps at 10, 9, 8 and 4, and a two-move warm-up. With these values the warm-up ends within a few cycles of a load. Feedback lasts long enough for the tap parity to wrap through all positions, and mixed stall and shift patterns among the lanes occur within a short run. Every cycle is checked against a bench reference model of all three lanes and the warm-up count.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic {
    LANE_SERIAL   = 1'b0,
    LANE_FEEDBACK = 1'b1
  } lane_kind_e;
endpackage

// File: rtl/shreg_taps.sv
module shreg_taps #(
  parameter int unsigned        WIDTH    = 11,
  parameter logic [WIDTH-1:0]   TAP_MASK = 11'h710
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             fb_o
);
  logic [WIDTH-1:0] sel;

  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (TAP_MASK[i]) begin : g_on
      assign sel[i] = vec_i[i];
    end else begin : g_off
      assign sel[i] = 1'b0;
    end
  end

  assign fb_o = ^sel;
endmodule

// File: rtl/shreg_warmup.sv
module shreg_warmup #(
  parameter int unsigned WARM_MOVES = 2,
  localparam int unsigned CW = $clog2(WARM_MOVES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic ready_o
);
  localparam logic [CW-1:0] DONE = CW'(WARM_MOVES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (step_i && cnt_q != DONE) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == DONE);
endmodule

// File: rtl/shreg_lane.sv
module shreg_lane #(
  parameter int unsigned WIDTH    = 11,
  parameter int unsigned MOVE_BIT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] ld_val_i,
  input  logic             en_i,
  input  logic             in_bit_i,
  output logic [WIDTH-1:0] q_o,
  output logic             move_o
);
  logic [WIDTH-1:0] q_q;

  // self-gated: the lane's own bit decides the move
  assign move_o = en_i && !load_i && q_q[MOVE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (load_i) q_q <= ld_val_i;
    else if (move_o) q_q <= {q_q[WIDTH-2:0], in_bit_i};
  end

  assign q_o = q_q;
endmodule

// File: rtl/shreg_bank.sv
module shreg_bank
  import shreg_pkg::*;
#(
  parameter int unsigned      WIDTH      = 11,
  parameter int unsigned      MOVE_BIT   = 5,
  parameter int unsigned      NUM_LANES  = 3,
  parameter int unsigned      WARM_MOVES = 2,
  parameter logic [WIDTH-1:0] TAP_MASK   = 11'h710,
  localparam int unsigned     FB_LANE    = NUM_LANES - 1
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                load_i,
  input  logic                                en_i,
  input  logic                                ser_i,
  input  logic [NUM_LANES-1:0][WIDTH-1:0]     ld_val_i,
  output logic [NUM_LANES-1:0][WIDTH-1:0]     q_o,
  output logic [NUM_LANES-1:0]                ser_o,
  output logic                                ready_o
);
  logic [NUM_LANES-1:0] move;
  logic [NUM_LANES-1:0] in_bit;
  logic                 fb;
  logic                 ready;

  shreg_taps #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) i_taps (
    .vec_i (q_o[FB_LANE]),
    .fb_o  (fb)
  );

  shreg_warmup #(.WARM_MOVES(WARM_MOVES)) i_warmup (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (load_i),
    .step_i  (move[FB_LANE]),
    .ready_o (ready)
  );

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    localparam lane_kind_e KIND = (k == FB_LANE) ? LANE_FEEDBACK : LANE_SERIAL;

    if (KIND == LANE_FEEDBACK) begin : g_fb
      // serial fill until the top bits are valid
      assign in_bit[k] = ready ? fb : ser_i;
    end else begin : g_ser
      assign in_bit[k] = ser_i;
    end

    shreg_lane #(.WIDTH(WIDTH), .MOVE_BIT(MOVE_BIT)) i_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load_i),
      .ld_val_i (ld_val_i[k]),
      .en_i     (en_i),
      .in_bit_i (in_bit[k]),
      .q_o      (q_o[k]),
      .move_o   (move[k])
    );

    assign ser_o[k] = q_o[k][WIDTH-1];
  end

  assign ready_o = ready;
endmodule

// File: rtl/shreg_bank_chk.sv
module shreg_bank_chk #(
  parameter int unsigned      WIDTH      = 11,
  parameter int unsigned      MOVE_BIT   = 5,
  parameter int unsigned      NUM_LANES  = 3,
  parameter logic [WIDTH-1:0] TAP_MASK   = 11'h710
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            load_i,
  input logic                            en_i,
  input logic                            ser_i,
  input logic [NUM_LANES-1:0][WIDTH-1:0] ld_val_i,
  input logic [NUM_LANES-1:0][WIDTH-1:0] q_o,
  input logic [NUM_LANES-1:0]            ser_o,
  input logic                            ready_o
);
  localparam int unsigned FB = NUM_LANES - 1;

  // R2
  load_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (q_o == $past(ld_val_i)) && !ready_o);

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !en_i) |=> $stable(q_o) && $stable(ready_o));

  // R8
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !load_i) |=> ready_o);

  // R7
  ready_on_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(en_i && !load_i && q_o[FB][MOVE_BIT]));

  // R8
  fb_insert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && en_i && !load_i && q_o[FB][MOVE_BIT])
      |=> q_o[FB][0] == $past(^(q_o[FB] & TAP_MASK)));

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane_chk
    // R4
    stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !load_i && !q_o[k][MOVE_BIT]) |=> $stable(q_o[k]));

    // R5
    shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !load_i && q_o[k][MOVE_BIT])
        |=> q_o[k][WIDTH-1:1] == $past(q_o[k][WIDTH-2:0]));

    // R9
    ser_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ser_o[k] == q_o[k][WIDTH-1]);

    if (k != FB) begin : g_ser_in
      // R6
      ser_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !load_i && q_o[k][MOVE_BIT]) |=> q_o[k][0] == $past(ser_i));
    end
  end
endmodule

bind shreg_bank shreg_bank_chk #(
  .WIDTH(WIDTH), .MOVE_BIT(MOVE_BIT), .NUM_LANES(NUM_LANES), .TAP_MASK(TAP_MASK)
) i_shreg_bank_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .en_i(en_i), .ser_i(ser_i),
  .ld_val_i(ld_val_i), .q_o(q_o), .ser_o(ser_o), .ready_o(ready_o)
);

// File: tb/test_shreg_bank.sv
`timescale 1ns/1ps
module test_shreg_bank;
  localparam int W = 11;
  localparam int N = 3;
  localparam logic [W-1:0] MASK = 11'h710;

  typedef struct packed {
    logic ld; logic en; logic ser;
    logic [W-1:0] c; logic [W-1:0] b; logic [W-1:0] a;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 11'h7e5, 11'h000, 11'h020},
    '{1'b0, 1'b1, 1'b1, 11'h000, 11'h000, 11'h000},
    '{1'b0, 1'b1, 1'b0, 11'h000, 11'h000, 11'h000},
    '{1'b0, 1'b1, 1'b1, 11'h000, 11'h000, 11'h000},
    '{1'b0, 1'b0, 1'b1, 11'h000, 11'h000, 11'h000},
    '{1'b0, 1'b1, 1'b1, 11'h000, 11'h000, 11'h000},
    '{1'b0, 1'b1, 1'b0, 11'h000, 11'h000, 11'h000},
    '{1'b1, 1'b1, 1'b1, 11'h3ff, 11'h7ff, 11'h060},
    '{1'b0, 1'b1, 1'b1, 11'h000, 11'h000, 11'h000},
    '{1'b0, 1'b1, 1'b1, 11'h000, 11'h000, 11'h000},
    '{1'b0, 1'b1, 1'b0, 11'h000, 11'h000, 11'h000},
    '{1'b0, 1'b1, 1'b0, 11'h000, 11'h000, 11'h000},
    '{1'b0, 1'b1, 1'b1, 11'h000, 11'h000, 11'h000},
    '{1'b0, 1'b1, 1'b0, 11'h000, 11'h000, 11'h000},
    '{1'b0, 1'b1, 1'b1, 11'h000, 11'h000, 11'h000},
    '{1'b0, 1'b1, 1'b1, 11'h000, 11'h000, 11'h000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0, en = 1'b0, ser = 1'b0;
  logic [N-1:0][W-1:0] ld_val = '0;
  logic [N-1:0][W-1:0] q;
  logic [N-1:0] ser_out;
  logic ready;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [W-1:0] m [N];
  int m_cnt;

  always #10 clk = ~clk;

  shreg_bank i_shreg_bank (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .en_i(en), .ser_i(ser),
    .ld_val_i(ld_val), .q_o(q), .ser_o(ser_out), .ready_o(ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < N; k++) m[k] = '0;
    m_cnt = 0;
  endtask

  // one clock: drive at negedge, model at posedge, compare just after
  task automatic step(input logic l, input logic e, input logic s,
                      input logic [W-1:0] va, input logic [W-1:0] vb, input logic [W-1:0] vc);
    string tag [N];
    logic nb;
    @(negedge clk);
    load = l; en = e; ser = s;
    ld_val[0] = va; ld_val[1] = vb; ld_val[2] = vc;
    @(posedge clk);
    for (int k = 0; k < N; k++) begin
      if (l)                tag[k] = "R2";
      else if (!e)          tag[k] = "R3";
      else if (!m[k][5])    tag[k] = "R4";
      else if (k < N-1)     tag[k] = "R6";
      else if (m_cnt == 2)  tag[k] = "R8";
      else                  tag[k] = "R7";
    end
    if (l) begin
      m[0] = va; m[1] = vb; m[2] = vc; m_cnt = 0;
    end else if (e) begin
      for (int k = 0; k < N; k++) begin
        if (m[k][5]) begin
          nb = (k == N-1 && m_cnt == 2) ? ^(m[k] & MASK) : s;
          m[k] = {m[k][W-2:0], nb};
          if (k == N-1 && m_cnt < 2) m_cnt++;
        end
      end
    end
    #1;
    for (int k = 0; k < N; k++) begin
      chk(tag[k], 32'(q[k]), 32'(m[k]));
      chk("R9", 32'(ser_out[k]), 32'(m[k][W-1]));
    end
    chk("R8 ready", 32'(ready), 32'(m_cnt == 2));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    model_reset();
    #5;
    chk("R1 q", 32'(q), 32'(0));
    chk("R1 ready", 32'(ready), 32'(0));
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 q", 32'(q), 32'(0));
    chk("R1 ready", 32'(ready), 32'(0));

    for (int i = 0; i < NV; i++)
      step(VECS[i].ld, VECS[i].en, VECS[i].ser, VECS[i].a, VECS[i].b, VECS[i].c);

    // R5 and R10: lane 0 shifts, lane 1 stalls, lane 2 shifts, same cycle
    step(1'b1, 1'b0, 1'b0, 11'h431, 11'h000, 11'h020);
    step(1'b0, 1'b1, 1'b0, 11'h000, 11'h000, 11'h000);
    chk("R5 shift", 32'(q[0]), 32'(11'h062));
    chk("R10 stall lane1", 32'(q[1]), 32'(11'h000));
    chk("R10 shift lane2", 32'(q[2]), 32'(11'h040));

    // R4: lane 2 stalled, warm-up must not advance
    step(1'b1, 1'b0, 1'b0, 11'h020, 11'h020, 11'h400);
    repeat (4) step(1'b0, 1'b1, 1'b1, 11'h000, 11'h000, 11'h000);
    chk("R4 no warm-up", 32'(ready), 32'(0));
    chk("R4 lane2 held", 32'(q[2]), 32'(11'h400));

    // R3: enable low holds everything, including ready
    step(1'b1, 1'b0, 1'b0, 11'h7ff, 11'h7ff, 11'h7ff);
    repeat (2) step(1'b0, 1'b1, 1'b1, 11'h000, 11'h000, 11'h000);
    chk("R7 ready after two moves", 32'(ready), 32'(1));
    repeat (3) step(1'b0, 1'b0, 1'b0, 11'h000, 11'h000, 11'h000);
    chk("R3 ready held", 32'(ready), 32'(1));

    // R8: feedback from 0x7ff-derived value: tap parity
    step(1'b0, 1'b1, 1'b0, 11'h000, 11'h000, 11'h000);
    chk("R8 fb bit", 32'(q[2][0]), 32'(^(11'h7ff & MASK)));

    // R2: load during enable clears ready
    step(1'b1, 1'b1, 1'b1, 11'h155, 11'h2aa, 11'h0f0);
    chk("R2 load over shift", 32'(q[2]), 32'(11'h0f0));

    // mixed long run against the model
    lfsr = 16'hace1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 37 == 0)
        step(1'b1, 1'b1, lfsr[0], lfsr[10:0], lfsr[15:5], {lfsr[4:0], lfsr[15:10]});
      else
        step(1'b0, lfsr[3] | lfsr[7], lfsr[1], 11'h000, 11'h000, 11'h000);
    end

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async", 32'(q), 32'(0));
    chk("R1 async ready", 32'(ready), 32'(0));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule